// File: doc/BRIEF.md
# Receive Latency Flush Timer

This block decides when a partly filled receive FIFO should be handed upstream as a short packet instead of waiting for it to fill. A millisecond counter, clocked by an external 1 ms tick, restarts on every byte pushed into the FIFO. It advances only while the FIFO holds data. When the count reaches the programmed deadline, the block raises a flush request. A request is also raised at once when the FIFO level reaches a packet-size threshold, or when a pushed byte matches a configured event character.

The flush request stays high until the upstream side acknowledges it. The acknowledge clears the counter and disarms it. The counter arms again only when a new byte arrives, so a FIFO that was emptied by the flush does not produce a second, empty request. The deadline sits in an internal register that resets to 16 ms. It is written through a one-cycle write strobe with a value from 1 to 255.

Top module: `rx_flush_timer`

## Requirements
- R1: After reset, flushReq is low and the deadline register holds 16, so a single push followed by 15 ticks leaves flushReq low and the 16th tick raises it.
- R2: A write of value T (1..255) sets the deadline. After the last push, with the FIFO non-empty, flushReq stays low through tick T-1 and is high in the cycle after the clock edge that samples tick T.
- R3: A deadline write of 0 behaves as a deadline of 1.
- R4: Every push restarts the counter from zero, so ticks that came before the latest push do not count toward the deadline.
- R5: Ticks that arrive while fifoLevel is 0 do not advance the counter and cannot raise flushReq.
- R6: Once raised, flushReq stays high until flushAck is sampled high. In the cycle after that edge, flushReq is low.
- R7: After an acknowledge, the counter is disarmed. Ticks alone, with data still reported in the FIFO, raise no request until the next push.
- R8: While evtEnable is high, a push whose byte equals evtChar raises flushReq on the next cycle. While evtEnable is low, the same push has no effect.
- R9: When pktThreshold is non-zero and fifoLevel is greater than or equal to it, flushReq is raised on the next cycle. A pktThreshold of 0 turns this trigger off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msTick | input | 1 | One-cycle pulse every millisecond |
| fifoLevel | input | LEVEL_W | Current FIFO occupancy |
| fifoPush | input | 1 | A byte is written into the FIFO this cycle |
| pushByte | input | BYTE_W | The byte being pushed |
| cfgWrite | input | 1 | Write strobe for the deadline register |
| cfgTimeout | input | TIME_W | Deadline in ms; 0 is taken as 1 |
| evtEnable | input | 1 | Enables the event-character trigger |
| evtChar | input | BYTE_W | Event character value |
| pktThreshold | input | LEVEL_W | Level that forces a flush; 0 disables |
| flushAck | input | 1 | Upstream accepts the flush request |
| flushReq | output | 1 | Flush request, held until acknowledged |

## Verification
The bench walks deadlines across the range: the smallest, the largest and a written zero. Each is checked one tick before the expiry and exactly at it, so a counter that is off by one fires a tick early or a tick late. Directed cases cover the following faults:
- a push in mid-count that fails to restart the counter, which gives an early request;
- ticks counted while the FIFO is empty;
- a request that drops without an acknowledge;
- a counter left armed after the acknowledge, which gives a spurious second request.

The event trigger and the threshold trigger are each checked in both their enabled and disabled settings. A design that ignores either enable would raise a request where none is due.

// File: rtl/rx_flush_pkg.sv
package rx_flush_pkg;
  // Strobes issued by the control to the timer datapath
  typedef struct packed {
    logic restart;  // clear the millisecond count
    logic advance;  // add one millisecond
  } timerCtrl_t;
endpackage

// File: rtl/rx_flush_datapath.sv
module rx_flush_datapath
  import rx_flush_pkg::*;
#(
  parameter int LEVEL_W = 10,
  parameter int BYTE_W = 8,
  parameter int TIME_W = 8,
  parameter int RESET_TIMEOUT = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  timerCtrl_t         ctrl,
  input  logic               cfgWrite,
  input  logic [TIME_W-1:0]  cfgTimeout,
  input  logic               fifoPush,
  input  logic [BYTE_W-1:0]  pushByte,
  input  logic               evtEnable,
  input  logic [BYTE_W-1:0]  evtChar,
  input  logic [LEVEL_W-1:0] fifoLevel,
  input  logic [LEVEL_W-1:0] pktThreshold,
  output logic               expireNext,
  output logic               evtHit,
  output logic               overThresh,
  output logic               levelNonZero
);
  localparam int CMP_W = TIME_W + 1;
  localparam logic [TIME_W-1:0] DEFAULT_LIMIT = TIME_W'(RESET_TIMEOUT);
  localparam logic [TIME_W-1:0] MIN_LIMIT = TIME_W'(1);

  logic [TIME_W-1:0] limitReg;
  logic [TIME_W-1:0] msCount;

  // Deadline register; a zero write is taken as the minimum deadline
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limitReg <= DEFAULT_LIMIT;
    end else if (cfgWrite) begin
      limitReg <= (cfgTimeout == '0) ? MIN_LIMIT : cfgTimeout;
    end
  end

  // Millisecond counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msCount <= '0;
    end else if (ctrl.restart) begin
      msCount <= '0;
    end else if (ctrl.advance) begin
      msCount <= msCount + 1'b1;
    end
  end

  // Compare one bit wider so the count cannot wrap past the limit
  assign expireNext   = (CMP_W'(msCount) + CMP_W'(1)) >= CMP_W'(limitReg);
  assign evtHit       = fifoPush && evtEnable && (pushByte == evtChar);
  assign overThresh   = (pktThreshold != '0) && (fifoLevel >= pktThreshold);
  assign levelNonZero = (fifoLevel != '0);
endmodule

// File: rtl/rx_flush_control.sv
module rx_flush_control
  import rx_flush_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       fifoPush,
  input  logic       flushAck,
  input  logic       expireNext,
  input  logic       evtHit,
  input  logic       overThresh,
  input  logic       levelNonZero,
  output timerCtrl_t ctrl,
  output logic       flushReq
);
  logic armed;
  logic ackTaken;
  logic fire;

  assign ackTaken     = flushReq && flushAck;
  assign ctrl.advance = msTick && armed && levelNonZero && !flushReq && !fifoPush;
  assign fire         = !flushReq && (evtHit || overThresh || (ctrl.advance && expireNext));
  assign ctrl.restart = fifoPush || ackTaken || fire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flushReq <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (ackTaken) begin
        flushReq <= 1'b0;
      end else if (fire) begin
        flushReq <= 1'b1;
      end
      if (fifoPush) begin
        armed <= 1'b1;
      end else if (ackTaken) begin
        armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_flush_timer.sv
module rx_flush_timer
  import rx_flush_pkg::*;
#(
  parameter int LEVEL_W = 10,
  parameter int BYTE_W = 8,
  parameter int TIME_W = 8,
  parameter int RESET_TIMEOUT = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               msTick,
  input  logic [LEVEL_W-1:0] fifoLevel,
  input  logic               fifoPush,
  input  logic [BYTE_W-1:0]  pushByte,
  input  logic               cfgWrite,
  input  logic [TIME_W-1:0]  cfgTimeout,
  input  logic               evtEnable,
  input  logic [BYTE_W-1:0]  evtChar,
  input  logic [LEVEL_W-1:0] pktThreshold,
  input  logic               flushAck,
  output logic               flushReq
);
  timerCtrl_t ctrl;
  logic expireNext;
  logic evtHit;
  logic overThresh;
  logic levelNonZero;

  rx_flush_datapath #(
    .LEVEL_W(LEVEL_W), .BYTE_W(BYTE_W), .TIME_W(TIME_W), .RESET_TIMEOUT(RESET_TIMEOUT)
  ) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .cfgWrite(cfgWrite), .cfgTimeout(cfgTimeout),
    .fifoPush(fifoPush), .pushByte(pushByte),
    .evtEnable(evtEnable), .evtChar(evtChar),
    .fifoLevel(fifoLevel), .pktThreshold(pktThreshold),
    .expireNext(expireNext), .evtHit(evtHit),
    .overThresh(overThresh), .levelNonZero(levelNonZero)
  );

  rx_flush_control uCtrl (
    .clk(clk), .rstN(rstN), .msTick(msTick), .fifoPush(fifoPush),
    .flushAck(flushAck), .expireNext(expireNext), .evtHit(evtHit),
    .overThresh(overThresh), .levelNonZero(levelNonZero),
    .ctrl(ctrl), .flushReq(flushReq)
  );
endmodule

// File: rtl/rx_flush_timer_checker.sv
module rx_flush_timer_checker #(
  parameter int LEVEL_W = 10,
  parameter int BYTE_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [LEVEL_W-1:0] fifoLevel,
  input logic               fifoPush,
  input logic [BYTE_W-1:0]  pushByte,
  input logic               evtEnable,
  input logic [BYTE_W-1:0]  evtChar,
  input logic [LEVEL_W-1:0] pktThreshold,
  input logic               flushAck,
  input logic               flushReq
);
  p_hold_until_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq && !flushAck) |=> flushReq);

  p_ack_drops_r6: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq && flushAck) |=> !flushReq);

  p_event_fires_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!flushReq && fifoPush && evtEnable && (pushByte == evtChar)) |=> flushReq);

  p_threshold_fires_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!flushReq && (pktThreshold != '0) && (fifoLevel >= pktThreshold)) |=> flushReq);

  p_quiet_when_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!flushReq && (fifoLevel == '0) && !fifoPush) |=> !flushReq);
endmodule

bind rx_flush_timer rx_flush_timer_checker #(.LEVEL_W(LEVEL_W), .BYTE_W(BYTE_W)) uChecker (
  .clk(clk), .rstN(rstN), .fifoLevel(fifoLevel), .fifoPush(fifoPush),
  .pushByte(pushByte), .evtEnable(evtEnable), .evtChar(evtChar),
  .pktThreshold(pktThreshold), .flushAck(flushAck), .flushReq(flushReq)
);

// File: tb/tb_rx_flush_timer.sv
module tb_rx_flush_timer;
  localparam int LEVEL_W = 10;
  localparam int BYTE_W = 8;
  localparam int TIME_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0;
  logic [LEVEL_W-1:0] fifoLevel = '0;
  logic fifoPush = 1'b0;
  logic [BYTE_W-1:0] pushByte = '0;
  logic cfgWrite = 1'b0;
  logic [TIME_W-1:0] cfgTimeout = '0;
  logic evtEnable = 1'b0;
  logic [BYTE_W-1:0] evtChar = 8'h0D;
  logic [LEVEL_W-1:0] pktThreshold = '0;
  logic flushAck = 1'b0;
  logic flushReq;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  rx_flush_timer #(.LEVEL_W(LEVEL_W), .BYTE_W(BYTE_W), .TIME_W(TIME_W)) dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .fifoLevel(fifoLevel),
    .fifoPush(fifoPush), .pushByte(pushByte), .cfgWrite(cfgWrite),
    .cfgTimeout(cfgTimeout), .evtEnable(evtEnable), .evtChar(evtChar),
    .pktThreshold(pktThreshold), .flushAck(flushAck), .flushReq(flushReq)
  );

  // Vector: {deadline written, ticks given after push, expected request}
  localparam int NVEC = 8;
  localparam logic [16:0] VEC [NVEC] = '{
    {8'd3,   8'd2,   1'b0},
    {8'd3,   8'd3,   1'b1},
    {8'd1,   8'd1,   1'b1},
    {8'd0,   8'd1,   1'b1},
    {8'd5,   8'd4,   1'b0},
    {8'd5,   8'd5,   1'b1},
    {8'd255, 8'd254, 1'b0},
    {8'd255, 8'd255, 1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: flushReq=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) msTick = 1'b1;
      @(negedge clk) msTick = 1'b0;
    end
  endtask

  task automatic pushOne(input logic [BYTE_W-1:0] b, input logic [LEVEL_W-1:0] lvl);
    @(negedge clk);
    fifoPush = 1'b1; pushByte = b; fifoLevel = lvl;
    @(negedge clk);
    fifoPush = 1'b0;
  endtask

  task automatic writeLimit(input logic [TIME_W-1:0] v);
    @(negedge clk);
    cfgWrite = 1'b1; cfgTimeout = v;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic ackOnce();
    @(negedge clk) flushAck = 1'b1;
    @(negedge clk) flushAck = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    check("R1 reset", flushReq, 1'b0);
    rstN = 1'b1;
    idle(2);
    check("R1 idle after reset", flushReq, 1'b0);

    // R1: default 16 ms deadline
    pushOne(8'h41, 10'd1);
    ticks(15);
    check("R1 default before 16", flushReq, 1'b0);
    ticks(1);
    check("R1 default at 16", flushReq, 1'b1);
    ackOnce();
    check("R6 ack clears", flushReq, 1'b0);

    // R2/R3: table walk
    for (int v = 0; v < NVEC; v++) begin
      fifoLevel = '0;
      writeLimit(VEC[v][16:9]);
      pushOne(8'h30, 10'd1);
      ticks(int'(VEC[v][8:1]));
      check(VEC[v][16:9] == 8'd0 ? "R3 zero deadline" : "R2 deadline", flushReq, VEC[v][0]);
      ackOnce();
    end

    // R4: a push mid-count restarts
    writeLimit(8'd4);
    pushOne(8'h31, 10'd1);
    ticks(3);
    pushOne(8'h32, 10'd2);
    ticks(3);
    check("R4 restart no early fire", flushReq, 1'b0);
    ticks(1);
    check("R4 fire after restart", flushReq, 1'b1);

    // R6: held without ack
    idle(10);
    check("R6 held", flushReq, 1'b1);
    ackOnce();
    check("R6 ack clears", flushReq, 1'b0);

    // R7: disarmed after ack, data still reported
    ticks(8);
    check("R7 no rearm without push", flushReq, 1'b0);

    // R5: empty FIFO freezes counter
    writeLimit(8'd2);
    pushOne(8'h33, 10'd1);
    fifoLevel = '0;
    ticks(10);
    check("R5 empty no fire", flushReq, 1'b0);
    fifoLevel = 10'd1;
    ticks(1);
    check("R5 one counted tick", flushReq, 1'b0);
    ticks(1);
    check("R5 fires once data present", flushReq, 1'b1);
    ackOnce();

    // R8: event character
    writeLimit(8'd200);
    evtEnable = 1'b0;
    pushOne(8'h0D, 10'd2);
    check("R8 disabled no effect", flushReq, 1'b0);
    evtEnable = 1'b1;
    pushOne(8'h0C, 10'd3);
    check("R8 non-matching byte", flushReq, 1'b0);
    pushOne(8'h0D, 10'd4);
    check("R8 match fires", flushReq, 1'b1);
    ackOnce();
    evtEnable = 1'b0;

    // R9: threshold
    pktThreshold = '0;
    pushOne(8'h50, 10'd500);
    idle(2);
    check("R9 zero threshold off", flushReq, 1'b0);
    fifoLevel = '0;
    pktThreshold = 10'd4;
    idle(1);
    @(negedge clk) fifoLevel = 10'd3;
    @(negedge clk);
    check("R9 below threshold", flushReq, 1'b0);
    fifoLevel = 10'd4;
    @(negedge clk);
    check("R9 at threshold", flushReq, 1'b1);
    fifoLevel = '0;
    ackOnce();
    check("R6 ack after threshold", flushReq, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule